// File: doc/BRIEF.md
# Serial Audio Stream Kind Detector

This block watches one serial audio line and decides whether it carries PCM or 1-bit DSD. In PCM operation the line is a frame clock, so a 16-bit stretch of it is all zeros or all ones. In DSD operation the line carries data, and during silence or mute it repeats one of three fixed 16-bit idle signatures. The block classifies successive 16-bit windows of the line. A class must be seen on two windows in a row before the block acts on it.

Detection runs only inside an armed window. Arming needs a run of consecutive silent frames, where the frame strobe reports that both channels were zero. The length of the run is chosen by a 2-bit select. The first frame with nonzero data disarms the block. When the confirmed class differs from the current mode, the mode output flips and an internal reset pulse is raised for about three quarters of a frame, counted in bit-clock ticks. Clearing the enable freezes the mode.

Top module: `stream_kind_detect`

## Requirements
- R1: After reset, `mode_dsd` is 0 (PCM) and `int_rst` is 0.
- R2: While armed, two consecutive windows that both match a DSD signature set `mode_dsd` to 1. The DSD signatures are 16'h6969, 16'h5555 and 16'h3333, and the first bit received is the MSB of the window.
- R3: While armed, two consecutive windows that are each 16'h0000 or 16'hFFFF set `mode_dsd` to 0.
- R4: The block arms after 2^(IDLE_BASE_LOG2+idle_sel) consecutive `frame_stb` pulses with `frame_silent` high. Windows received before that point have no effect on the mode.
- R5: A `frame_stb` pulse with `frame_silent` low disarms the block. Windows received afterwards, up to the next arming, have no effect on the mode.
- R6: While `auto_en` is low, `mode_dsd` holds its value and the arming count is cleared.
- R7: A change of `mode_dsd` raises `int_rst` for exactly RST_BITS `bit_stb` ticks, where RST_BITS = 3*FRAME_BITS/4. A confirmation that matches the current mode raises no pulse.
- R8: Two windows in a row confirm a class only if both have that same class. A window that matches no signature breaks the pair, and a window of the other class breaks it too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe marking a bit-clock sample of the line |
| line_bit | input | 1 | Sampled level of the monitored line, valid with `bit_stb` |
| frame_stb | input | 1 | One-cycle strobe at the end of each audio frame |
| frame_silent | input | 1 | High with `frame_stb` when both channels were zero in that frame |
| auto_en | input | 1 | Enables automatic detection |
| idle_sel | input | 2 | Selects the silent run needed to arm (2^(IDLE_BASE_LOG2+idle_sel) frames) |
| mode_dsd | output | 1 | Detected mode: 0 PCM, 1 DSD |
| int_rst | output | 1 | Internal reset pulse raised on a mode change |

## Verification
On every cycle the assertions check four things. Any mode flip is accompanied by the reset pulse. The mode never moves while detection is disabled. The mode moves only two cycles after a bit tick. The pulse only falls on a bit tick. The bench scenarios cover what no cycle-local property can show: the exact signature values, the arming thresholds for several select codes, disarming by a nonzero frame, the exact pulse length, and the rule that a pair must be unbroken and of one class.

// File: rtl/skd_pkg.sv
package skd_pkg;
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_PCM  = 2'd1,
        CLS_DSD  = 2'd2
    } cls_e;

    localparam int WIN_BITS = 16;

    localparam logic [WIN_BITS-1:0] SIG_DSD_X = 16'h6969;
    localparam logic [WIN_BITS-1:0] SIG_DSD_Y = 16'h5555;
    localparam logic [WIN_BITS-1:0] SIG_DSD_Z = 16'h3333;

    function automatic cls_e classify(input logic [WIN_BITS-1:0] w);
        if (w == SIG_DSD_X || w == SIG_DSD_Y || w == SIG_DSD_Z)
            return CLS_DSD;
        else if (w == '0 || w == '1)
            return CLS_PCM;
        else
            return CLS_NONE;
    endfunction
endpackage

// File: rtl/skd_arm_timer.sv
module skd_arm_timer #(
    parameter int IDLE_BASE_LOG2 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic       frame_stb,
    input  logic       frame_silent,
    input  logic [1:0] idle_sel,
    output logic       armed
);
    localparam int CW = IDLE_BASE_LOG2 + 4;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] target;

    always_comb begin
        target = {{(CW-1){1'b0}}, 1'b1} << (IDLE_BASE_LOG2 + int'(idle_sel));
        st_d   = st_q;
        if (!auto_en) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (frame_stb) begin
            if (!frame_silent) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b0;
            end else if (!st_q.armed) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt + 1'b1 >= target)
                    st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/skd_window.sv
module skd_window
    import skd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic bit_stb,
    input  logic line_bit,
    output logic win_done,
    output cls_e win_cls
);
    localparam int PW = $clog2(WIN_BITS);

    typedef struct packed {
        logic [WIN_BITS-1:0] shreg;
        logic [PW-1:0]       pos;
        logic                done;
        cls_e                cls;
    } st_t;

    st_t st_d, st_q;
    logic [WIN_BITS-1:0] shifted;

    always_comb begin
        shifted    = {st_q.shreg[WIN_BITS-2:0], line_bit};
        st_d       = st_q;
        st_d.done  = 1'b0;
        if (!armed) begin
            st_d.pos = '0;
        end else if (bit_stb) begin
            st_d.shreg = shifted;
            st_d.pos   = st_q.pos + 1'b1;
            if (st_q.pos == PW'(WIN_BITS - 1)) begin
                st_d.done = 1'b1;
                st_d.cls  = classify(shifted);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{shreg: '0, pos: '0, done: 1'b0, cls: CLS_NONE};
        else        st_q <= st_d;
    end

    assign win_done = st_q.done;
    assign win_cls  = st_q.cls;
endmodule

// File: rtl/skd_mode_ctrl.sv
module skd_mode_ctrl
    import skd_pkg::*;
#(
    parameter int RST_BITS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic armed,
    input  logic bit_stb,
    input  logic win_done,
    input  cls_e win_cls,
    output logic mode_dsd,
    output logic int_rst
);
    localparam int RW = $clog2(RST_BITS + 1);

    typedef struct packed {
        cls_e          prev;
        logic          mode;
        logic [RW-1:0] rcnt;
    } st_t;

    st_t  st_d, st_q;
    logic flip;
    logic new_mode;

    always_comb begin
        st_d     = st_q;
        flip     = 1'b0;
        new_mode = (win_cls == CLS_DSD);
        if (!auto_en || !armed) begin
            st_d.prev = CLS_NONE;
        end else if (win_done) begin
            if (win_cls == CLS_NONE) begin
                st_d.prev = CLS_NONE;
            end else if (win_cls == st_q.prev) begin
                if (new_mode != st_q.mode) begin
                    flip      = 1'b1;
                    st_d.mode = new_mode;
                    st_d.rcnt = RW'(RST_BITS);
                end
            end else begin
                st_d.prev = win_cls;
            end
        end
        if (!flip && bit_stb && st_q.rcnt != '0)
            st_d.rcnt = st_q.rcnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: CLS_NONE, mode: 1'b0, rcnt: '0};
        else        st_q <= st_d;
    end

    assign mode_dsd = st_q.mode;
    assign int_rst  = (st_q.rcnt != '0);
endmodule

// File: rtl/stream_kind_detect.sv
module stream_kind_detect
    import skd_pkg::*;
#(
    parameter int IDLE_BASE_LOG2 = 10,
    parameter int FRAME_BITS     = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       line_bit,
    input  logic       frame_stb,
    input  logic       frame_silent,
    input  logic       auto_en,
    input  logic [1:0] idle_sel,
    output logic       mode_dsd,
    output logic       int_rst
);
    localparam int RST_BITS = (FRAME_BITS * 3) / 4;

    logic armed;
    logic win_done;
    cls_e win_cls;

    skd_arm_timer #(.IDLE_BASE_LOG2(IDLE_BASE_LOG2)) u_arm (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .frame_stb(frame_stb),
        .frame_silent(frame_silent), .idle_sel(idle_sel), .armed(armed)
    );

    skd_window u_win (
        .clk(clk), .rst_n(rst_n), .armed(armed), .bit_stb(bit_stb),
        .line_bit(line_bit), .win_done(win_done), .win_cls(win_cls)
    );

    skd_mode_ctrl #(.RST_BITS(RST_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .armed(armed),
        .bit_stb(bit_stb), .win_done(win_done), .win_cls(win_cls),
        .mode_dsd(mode_dsd), .int_rst(int_rst)
    );
endmodule

// File: rtl/skd_checker.sv
module skd_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic auto_en,
    input logic mode_dsd,
    input logic int_rst
);
    AST_FLIP_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_dsd) |-> int_rst);                              // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> $stable(mode_dsd));                              // R6
    AST_FLIP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_dsd) |-> $past(bit_stb, 2));                    // R2
    AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_rst) |-> $past(bit_stb));                           // R7
endmodule

bind stream_kind_detect skd_checker u_skd_checker (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .auto_en(auto_en),
    .mode_dsd(mode_dsd), .int_rst(int_rst)
);

// File: tb/test_stream_kind_detect.sv
module test_stream_kind_detect;
    localparam int BASE   = 2;
    localparam int FBITS  = 8;
    localparam int RBITS  = (FBITS * 3) / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, line_bit = 1'b0, frame_stb = 1'b0, frame_silent = 1'b0;
    logic auto_en = 1'b0;
    logic [1:0] idle_sel = 2'd0;
    logic mode_dsd, int_rst;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  mode;
        logic  rst;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    stream_kind_detect #(.IDLE_BASE_LOG2(BASE), .FRAME_BITS(FBITS)) i_stream_kind_detect (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .line_bit(line_bit),
        .frame_stb(frame_stb), .frame_silent(frame_silent), .auto_en(auto_en),
        .idle_sel(idle_sel), .mode_dsd(mode_dsd), .int_rst(int_rst)
    );

    // monitor: pops expected items and compares them away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (mode_dsd !== e.mode || int_rst !== e.rst) begin
                    bad++;
                    $display("FAIL %s: mode=%0b rst=%0b expected mode=%0b rst=%0b",
                             e.tag, mode_dsd, int_rst, e.mode, e.rst);
                end
            end
        end
    end

    task automatic expect_out(input logic m, input logic r, input string tag);
        q.push_back('{mode: m, rst: r, tag: tag});
        repeat (2) @(negedge clk);
    endtask

    task automatic tick_bit(input logic b);
        @(negedge clk);
        bit_stb = 1'b1; line_bit = b;
        @(negedge clk);
        bit_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input logic silent);
        @(negedge clk);
        frame_stb = 1'b1; frame_silent = silent;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) tick_bit(w[i]);
    endtask

    task automatic rearm(input int frames);
        frame(1'b0);
        repeat (frames) frame(1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 1'b0, "R1 reset state");

        auto_en = 1'b1; idle_sel = 2'd0;
        repeat (4) frame(1'b1);
        send_word(16'h6969); send_word(16'h6969);
        expect_out(1'b1, 1'b1, "R2 signature 6969 twice");

        repeat (RBITS - 1) tick_bit(1'b0);
        expect_out(1'b1, 1'b1, "R7 pulse before last tick");
        tick_bit(1'b0);
        expect_out(1'b1, 1'b0, "R7 pulse after RST_BITS ticks");

        frame(1'b0);
        send_word(16'h0000); send_word(16'h0000);
        expect_out(1'b1, 1'b0, "R5 disarmed by nonzero frame");

        auto_en = 1'b0;
        repeat (6) frame(1'b1);
        send_word(16'h0000); send_word(16'h0000);
        expect_out(1'b1, 1'b0, "R6 mode held while disabled");

        auto_en = 1'b1; idle_sel = 2'd1;
        repeat (7) frame(1'b1);
        send_word(16'h0000); send_word(16'h0000);
        expect_out(1'b1, 1'b0, "R4 one frame short of sel1 threshold");
        frame(1'b1);
        send_word(16'h0000); send_word(16'h0000);
        expect_out(1'b0, 1'b1, "R3 zeros twice after arming");

        rearm(8);
        send_word(16'h5555); send_word(16'h1234); send_word(16'h5555);
        expect_out(1'b0, 1'b0, "R8 unmatched window breaks pair");
        send_word(16'h5555);
        expect_out(1'b1, 1'b1, "R2 signature 5555 twice");
        send_word(16'hFFFF); send_word(16'hFFFF);
        expect_out(1'b0, 1'b1, "R3 ones twice");
        send_word(16'h3333); send_word(16'h0000); send_word(16'h3333);
        expect_out(1'b0, 1'b0, "R8 other class breaks pair");
        send_word(16'h3333);
        expect_out(1'b1, 1'b1, "R2 signature 3333 twice");
        send_word(16'h6969); send_word(16'h6969);
        expect_out(1'b1, 1'b0, "R7 no pulse when mode unchanged");

        idle_sel = 2'd2;
        rearm(15);
        send_word(16'h0000); send_word(16'h0000);
        expect_out(1'b1, 1'b0, "R4 one frame short of sel2 threshold");
        frame(1'b1);
        send_word(16'h0000); send_word(16'h0000);
        expect_out(1'b0, 1'b1, "R4 armed at sel2 threshold");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule